// File: doc/BRIEF.md
# Secondary Interrupt Controller with Per-Line Bypass

This block collects a vector of level-sensitive interrupt requests and folds them into one summary request for a primary interrupt controller. Software selects which requests take part in the summary through an enable mask that it updates with separate set and clear writes, so no read-modify-write sequence is needed. The raw levels and the masked levels can both be read back.

A restricted band of request lines (by default lines 21 to 30) can also skip the summary. When a line in that band has its bypass enable set, its raw level is copied straight onto the output line with the same index, so the primary controller sees it as a request of its own. The bypass enable also has set and clear writes. The summary sits on the top output line. Output lines below the band are always low.

The register bus has a byte address, a write strobe, write data and combinational read data. Bits [1:0] of the address are ignored. The inputs are assumed to be synchronous to the bus clock already.

Top module: `sic_passthru`

## Requirements
- R1: The register word is selected by busAddr[11:2] and address bits [1:0] are ignored. The window is 4 KiB (word indices 0 to 1023).
- R2: Reading word 1 returns the raw level register. This register takes the value of irqIn at every rising clock edge, so a change on an input shows one cycle later.
- R3: Reading word 0 returns the raw level ANDed with the enable mask.
- R4: Writing word 2 ORs busWrData into the enable mask, and reading word 2 returns the mask. Writing word 3 clears every mask bit that is written as one.
- R5: Reading word 4 returns raw level bit 0 in bit 0, with all other bits zero. A write of any nonzero value to word 4 sets mask bit 0. A write of any nonzero value to word 5 clears mask bit 0. A zero write to either word changes nothing.
- R6: Writing word 8 ORs busWrData AND 0x7FE00000 (bits 21 to 30 only) into the bypass enable register, and reading word 8 returns that register. Writing word 9 clears every bypass enable bit that is written as one.
- R7: irqOut[31] is high exactly when the raw level ANDed with the enable mask is nonzero.
- R8: For each line k from 21 to 30, irqOut[k] equals raw level bit k when bypass enable bit k is set, and is low otherwise. irqOut[20:0] are always low.
- R9: Reads of words 3, 5, 6, 7 and 9 to 1023 return zero. Writes to words 0, 1, 6, 7 and 10 to 1023 change neither the mask nor the bypass enables.
- R10: After a synchronous reset the enable mask, the bypass enables and the raw level are all zero, and every output line is low.
- R11: A register write takes effect on the clock edge that samples it. Read data and outputs show the new value in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 12 | Byte address within the register window |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| irqIn | input | 32 | Level-sensitive interrupt requests |
| irqOut | output | 32 | Bypass lines 21 to 30 and summary on line 31 |

## Verification
Every result here is due one cycle after its stimulus. An input change is visible in the raw level, the masked status and the output lines after the next rising edge, and a write changes the mask, the bypass enables, the outputs and the read data after the edge that samples it. The bench drives stimulus on the falling edge, lets one rising edge go by, and samples on the following falling edge. Because read data is combinational from the address, each read is sampled a short delay after the address is applied and well before the next rising edge.

// File: rtl/sic_pkg.sv
package sic_pkg;

  localparam int W_STATUS  = 0;
  localparam int W_RAW     = 1;
  localparam int W_ENSET   = 2;
  localparam int W_ENCLR   = 3;
  localparam int W_SOFTSET = 4;
  localparam int W_SOFTCLR = 5;
  localparam int W_PTSET   = 8;
  localparam int W_PTCLR   = 9;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_RAW,
    RD_MASK,
    RD_SOFT,
    RD_PT
  } rdSel_e;

  typedef struct packed {
    logic   enSet;
    logic   enClr;
    logic   softSet;
    logic   softClr;
    logic   ptSet;
    logic   ptClr;
    rdSel_e rdSel;
  } sicCtrl_t;

endpackage

// File: rtl/sic_ctrl.sv
module sic_ctrl
  import sic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output sicCtrl_t          ctrl
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              dataNonZero;

  assign word        = busAddr[ADDR_W-1:2];
  assign dataNonZero = |busWrData;

  always_comb begin
    ctrl       = '0;
    ctrl.rdSel = RD_NONE;
    case (word)
      WORD_W'(W_STATUS):  ctrl.rdSel = RD_STATUS;
      WORD_W'(W_RAW):     ctrl.rdSel = RD_RAW;
      WORD_W'(W_ENSET): begin
        ctrl.rdSel = RD_MASK;
        ctrl.enSet = busWrEn;
      end
      WORD_W'(W_ENCLR):   ctrl.enClr = busWrEn;
      WORD_W'(W_SOFTSET): begin
        ctrl.rdSel   = RD_SOFT;
        ctrl.softSet = busWrEn && dataNonZero;
      end
      WORD_W'(W_SOFTCLR): ctrl.softClr = busWrEn && dataNonZero;
      WORD_W'(W_PTSET): begin
        ctrl.rdSel = RD_PT;
        ctrl.ptSet = busWrEn;
      end
      WORD_W'(W_PTCLR):   ctrl.ptClr = busWrEn;
      default: ;
    endcase
  end

endmodule

// File: rtl/sic_datapath.sv
module sic_datapath
  import sic_pkg::*;
#(
  parameter int NUM_IN = 32,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  sicCtrl_t          ctrl,
  input  logic [NUM_IN-1:0] busWrData,
  input  logic [NUM_IN-1:0] irqIn,
  output logic [NUM_IN-1:0] busRdData,
  output logic [NUM_IN-1:0] irqOut,
  output logic [NUM_IN-1:0] levelQ,
  output logic [NUM_IN-1:0] enMask,
  output logic [NUM_IN-1:0] ptEn
);

  localparam int SUM_IDX = NUM_IN - 1;
  localparam logic [63:0] PT_WIDE = (64'd1 << (PT_HI + 1)) - (64'd1 << PT_LO);
  localparam logic [NUM_IN-1:0] PT_MASK = PT_WIDE[NUM_IN-1:0];

  logic [NUM_IN-1:0] maskNext;
  logic [NUM_IN-1:0] ptNext;
  logic [NUM_IN-1:0] masked;

  assign masked = levelQ & enMask;

  always_comb begin
    maskNext = enMask;
    if (ctrl.enSet)   maskNext = maskNext | busWrData;
    if (ctrl.enClr)   maskNext = maskNext & ~busWrData;
    if (ctrl.softSet) maskNext[0] = 1'b1;
    if (ctrl.softClr) maskNext[0] = 1'b0;
  end

  always_comb begin
    ptNext = ptEn;
    if (ctrl.ptSet) ptNext = ptNext | (busWrData & PT_MASK);
    if (ctrl.ptClr) ptNext = ptNext & ~busWrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      levelQ <= '0;
      enMask <= '0;
      ptEn   <= '0;
    end else begin
      levelQ <= irqIn;
      enMask <= maskNext;
      ptEn   <= ptNext;
    end
  end

  always_comb begin
    busRdData = '0;
    case (ctrl.rdSel)
      RD_STATUS: busRdData = masked;
      RD_RAW:    busRdData = levelQ;
      RD_MASK:   busRdData = enMask;
      RD_SOFT:   busRdData[0] = levelQ[0];
      RD_PT:     busRdData = ptEn;
      default:   busRdData = '0;
    endcase
  end

  for (genvar k = 0; k < NUM_IN; k++) begin : g_line
    if (k == SUM_IDX) begin : g_sum
      assign irqOut[k] = |masked;
    end else if (k >= PT_LO && k <= PT_HI) begin : g_pt
      assign irqOut[k] = ptEn[k] & levelQ[k];
    end else begin : g_low
      assign irqOut[k] = 1'b0;
    end
  end

endmodule

// File: rtl/sic_passthru.sv
module sic_passthru
  import sic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_IN = 32,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [NUM_IN-1:0] busWrData,
  output logic [NUM_IN-1:0] busRdData,
  input  logic [NUM_IN-1:0] irqIn,
  output logic [NUM_IN-1:0] irqOut
);

  sicCtrl_t          ctrl;
  logic [NUM_IN-1:0] levelQ;
  logic [NUM_IN-1:0] enMask;
  logic [NUM_IN-1:0] ptEn;

  sic_ctrl #(.ADDR_W(ADDR_W), .DATA_W(NUM_IN)) u_ctrl (
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .ctrl     (ctrl)
  );

  sic_datapath #(.NUM_IN(NUM_IN), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .busWrData(busWrData),
    .irqIn    (irqIn),
    .busRdData(busRdData),
    .irqOut   (irqOut),
    .levelQ   (levelQ),
    .enMask   (enMask),
    .ptEn     (ptEn)
  );

endmodule

// File: rtl/sic_passthru_chk.sv
module sic_passthru_chk
  import sic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_IN = 32,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [NUM_IN-1:0] busWrData,
  input logic [NUM_IN-1:0] busRdData,
  input logic [NUM_IN-1:0] irqIn,
  input logic [NUM_IN-1:0] irqOut,
  input logic [NUM_IN-1:0] levelQ,
  input logic [NUM_IN-1:0] enMask,
  input logic [NUM_IN-1:0] ptEn
);

  localparam int WORD_W  = ADDR_W - 2;
  localparam int SUM_IDX = NUM_IN - 1;
  localparam logic [63:0] PT_WIDE = (64'd1 << (PT_HI + 1)) - (64'd1 << PT_LO);
  localparam logic [NUM_IN-1:0] PT_MASK = PT_WIDE[NUM_IN-1:0];

  logic [WORD_W-1:0] word;
  logic              rdUnmapped;
  assign word = busAddr[ADDR_W-1:2];
  assign rdUnmapped = (word == WORD_W'(3)) || (word == WORD_W'(5)) ||
                      (word == WORD_W'(6)) || (word == WORD_W'(7)) ||
                      (word >= WORD_W'(9));

  p_level_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> levelQ == $past(irqIn));

  p_enset_r4: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && word == WORD_W'(W_ENSET)) |=>
      (enMask & $past(busWrData)) == $past(busWrData));

  p_enclr_r4: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && word == WORD_W'(W_ENCLR)) |=> (enMask & $past(busWrData)) == '0);

  p_ptrange_r6: assert property (@(posedge clk) disable iff (rst)
    (ptEn & ~PT_MASK) == '0);

  p_ptclr_r6: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && word == WORD_W'(W_PTCLR)) |=> (ptEn & $past(busWrData)) == '0);

  p_summary_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irqOut[SUM_IDX] == (($past(irqIn) & enMask) != '0));

  for (genvar k = PT_LO; k <= PT_HI; k++) begin : g_ptchk
    p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ptEn[k]) |-> irqOut[k] == $past(irqIn[k]));
    p_bypass_off_r8: assert property (@(posedge clk) disable iff (rst)
      !ptEn[k] |-> !irqOut[k]);
  end

  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    rdUnmapped |-> busRdData == '0);

endmodule

bind sic_passthru sic_passthru_chk #(
  .ADDR_W(ADDR_W), .NUM_IN(NUM_IN), .PT_LO(PT_LO), .PT_HI(PT_HI)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .irqIn    (irqIn),
  .irqOut   (irqOut),
  .levelQ   (levelQ),
  .enMask   (enMask),
  .ptEn     (ptEn)
);

// File: tb/tb_sic_passthru.sv
`timescale 1ns/1ps
module tb_sic_passthru;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] irqIn = '0;
  logic [31:0] irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  localparam logic [31:0] PTM = 32'h7FE0_0000;

  always #2.5 clk = ~clk;

  sic_passthru dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqIn(irqIn), .irqOut(irqOut)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
    end
  endtask

  task automatic wrWord(input int word, input logic [31:0] data, input logic [1:0] lo = 2'b00);
    @(negedge clk);
    busAddr = {word[9:0], lo};
    busWrData = data;
    busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    busWrData = '0;
  endtask

  task automatic rdWord(input int word, output logic [31:0] val, input logic [1:0] lo = 2'b00);
    busAddr = {word[9:0], lo};
    #0.5;
    val = busRdData;
  endtask

  task automatic setIn(input logic [31:0] v);
    @(negedge clk);
    irqIn = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] expOut(input logic [31:0] lvl, input logic [31:0] msk,
                                         input logic [31:0] pt);
    logic [31:0] o;
    o = lvl & pt & PTM;
    o[31] = |(lvl & msk);
    return o;
  endfunction

  task automatic tReset();
    logic [31:0] v;
    irqIn = 32'hFFFF_FFFF;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    irqIn = '0;
    rst = 1'b0;
    rdWord(1, v); chk("R10", "raw level after reset", v, 32'h0);
    rdWord(2, v); chk("R10", "mask after reset", v, 32'h0);
    rdWord(8, v); chk("R10", "bypass after reset", v, 32'h0);
    chk("R10", "outputs after reset", irqOut, 32'h0);
  endtask

  task automatic tRawStatus();
    logic [31:0] v;
    wrWord(2, 32'h0000_F0F0);
    rdWord(2, v); chk("R4", "mask after set", v, 32'h0000_F0F0);
    chk("R11", "no input yet, summary low", irqOut, 32'h0);
    @(negedge clk);
    irqIn = 32'h0000_0F00;
    rdWord(1, v); chk("R2", "raw before edge unchanged", v, 32'h0);
    @(negedge clk);
    rdWord(1, v); chk("R2", "raw one cycle later", v, 32'h0000_0F00);
    rdWord(0, v); chk("R3", "status disjoint", v, 32'h0);
    chk("R7", "summary low when disjoint", irqOut, 32'h0);
    setIn(32'h0000_3C00);
    rdWord(0, v); chk("R3", "status overlap", v, 32'h0000_3000);
    chk("R7", "summary high on overlap", irqOut, 32'h8000_0000);
    wrWord(3, 32'h0000_F000);
    rdWord(2, v); chk("R4", "mask after clear", v, 32'h0000_00F0);
    chk("R11", "summary drops after clear write", irqOut, 32'h0);
    wrWord(3, 32'hFFFF_FFFF);
    setIn(32'h0);
  endtask

  task automatic tSoftBit();
    logic [31:0] v;
    setIn(32'h0000_0003);
    rdWord(4, v); chk("R5", "word4 shows raw bit0 only", v, 32'h0000_0001);
    wrWord(4, 32'h0);
    rdWord(2, v); chk("R5", "zero write to word4 ignored", v, 32'h0);
    wrWord(4, 32'h0010_0000);
    rdWord(2, v); chk("R5", "nonzero write sets mask bit0", v, 32'h0000_0001);
    chk("R7", "summary from bit0", irqOut, 32'h8000_0000);
    wrWord(5, 32'h0);
    rdWord(2, v); chk("R5", "zero write to word5 ignored", v, 32'h0000_0001);
    wrWord(5, 32'h8000_0000);
    rdWord(2, v); chk("R5", "nonzero write clears mask bit0", v, 32'h0);
    setIn(32'h0);
  endtask

  task automatic tBypass();
    logic [31:0] v;
    wrWord(8, 32'hFFFF_FFFF);
    rdWord(8, v); chk("R6", "bypass set limited to 21..30", v, PTM);
    setIn(32'hFFFF_FFFF);
    chk("R8", "bypass lines follow inputs, low lines quiet", irqOut, expOut(32'hFFFF_FFFF, 32'h0, PTM));
    wrWord(9, 32'h0550_0000);
    rdWord(8, v); chk("R6", "bypass clear", v, PTM & ~32'h0550_0000);
    chk("R8", "cleared bypass lines low", irqOut, expOut(32'hFFFF_FFFF, 32'h0, PTM & ~32'h0550_0000));
    setIn(32'h2A80_0000);
    chk("R8", "bypass follows new pattern", irqOut, expOut(32'h2A80_0000, 32'h0, PTM & ~32'h0550_0000));
    wrWord(2, 32'h0000_0004);
    setIn(32'h0000_0004);
    chk("R7", "summary with bypass idle", irqOut, 32'h8000_0000);
    wrWord(9, 32'hFFFF_FFFF);
    wrWord(3, 32'hFFFF_FFFF);
    setIn(32'h0);
  endtask

  task automatic tUnmapped();
    logic [31:0] v;
    wrWord(2, 32'h1234_5678);
    wrWord(8, 32'h0120_0000);
    setIn(32'hFFFF_FFFF);
    foreach (v[i]) begin end
    for (int w = 3; w < 12; w++) begin
      if (w == 4 || w == 8) continue;
      rdWord(w, v); chk("R9", $sformatf("read of word %0d", w), v, 32'h0);
    end
    rdWord(1023, v); chk("R9", "read of last word", v, 32'h0);
    wrWord(0, 32'hFFFF_FFFF);
    wrWord(1, 32'hFFFF_FFFF);
    wrWord(6, 32'hFFFF_FFFF);
    wrWord(7, 32'hFFFF_FFFF);
    wrWord(10, 32'hFFFF_FFFF);
    wrWord(1023, 32'hFFFF_FFFF);
    rdWord(2, v); chk("R9", "mask untouched by unmapped writes", v, 32'h1234_5678);
    rdWord(8, v); chk("R9", "bypass untouched by unmapped writes", v, 32'h0120_0000);
    chk("R9", "outputs untouched", irqOut, expOut(32'hFFFF_FFFF, 32'h1234_5678, 32'h0120_0000));
    wrWord(3, 32'hFFFF_FFFF);
    wrWord(9, 32'hFFFF_FFFF);
    setIn(32'h0);
  endtask

  task automatic tAddrLow();
    logic [31:0] v;
    wrWord(2, 32'h00A0_0000, 2'b11);
    rdWord(2, v, 2'b10); chk("R1", "low address bits ignored", v, 32'h00A0_0000);
    wrWord(3, 32'h0020_0000, 2'b01);
    rdWord(2, v, 2'b01); chk("R1", "clear with low bits set", v, 32'h0080_0000);
    wrWord(3, 32'hFFFF_FFFF);
  endtask

  initial begin
    tReset();
    tRawStatus();
    tSoftBit();
    tBypass();
    tUnmapped();
    tAddrLow();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule